// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the bus-facing slave front end of a byte-wide serial memory with 32K locations. It takes SCL and SDA inputs that have already been synchronised and oversampled by the system clock, plus three chip-select strap levels. It frames bits into bytes and recognises Start and Stop conditions. It decodes the control byte and handles the two-byte word address. It keeps the internal address pointer and drives SDA through an open-drain output enable. Its transfers are byte write, page write, current-address read, random read and sequential read.

On the memory side it presents an address, a one-cycle write strobe with data, and read data returned by the array. It also has a commit pulse for a separate write-commit unit, and that unit reports back through a busy flag. While busy is high the engine refuses every control byte, so a bus master can poll for the end of an internal write cycle by sending control bytes until one is acknowledged.

Top module: `i2cmem_slave`

## Requirements
- R1: A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high. A Start at any point, including mid-byte, restarts reception of a control byte. A Stop at any point ends the transfer and leaves the address pointer unchanged. After reset, SDA is released and no write strobe or commit pulse is active.
- R2: The control byte's bit 0 selects read (1) or write (0). Bits 7:4 must be 1010 and bits 3:1 must equal strap_i. A matching control byte is acknowledged by holding SDA low for the whole high phase of the ninth clock.
- R3: If bits 7:4 or bits 3:1 of a control byte do not match, the engine gives no acknowledge and does not drive SDA again until the next Start.
- R4: While busy_i is high, no control byte is acknowledged, whether it is a read or a write. Once busy_i is low, the same byte is acknowledged.
- R5: After a write control byte, the engine takes the high address byte and then the low address byte, and acknowledges each. Bit 7 of the high byte is ignored. Each data byte that follows is acknowledged and produces one single-cycle write strobe at the current pointer.
- R6: Within a write, the pointer advances after each data byte. Only its low 6 bits (one 64-byte page) count, and they wrap from 63 to 0 while the upper bits stay as they are.
- R7: A Stop that follows at least one data byte of a write gives exactly one commit pulse. A Stop that follows only a control byte or address bytes gives none.
- R8: Random read: a write control byte and two address bytes, then a repeated Start and a read control byte, return data from the loaded address. Each master acknowledge makes the engine send the byte at the next address.
- R9: A current-address read returns the byte one past the last location that was written or read.
- R10: A read past address 0x7FFF continues at 0x0000.
- R11: After the master does not acknowledge a read byte, the engine releases SDA and sends no further data until a Start.
- R12: sda_oe_o changes value only when SCL has been sampled low on the current and the previous clock, so the engine never forms a false Start or Stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised serial clock level |
| sda_i | input | 1 | Synchronised serial data line level |
| strap_i | input | 3 | Chip-select strap levels compared with control bits 3:1 |
| busy_i | input | 1 | Internal write cycle in progress |
| mem_rdata_i | input | 8 | Array byte at mem_addr_o |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| mem_addr_o | output | 15 | Current address pointer |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_wdata_o | output | 8 | Data byte for the write strobe |
| commit_o | output | 1 | One-cycle request to start the internal write cycle |

## Verification
The hardest cases to reach are the ones tied to a moment that the bus protocol normally hides. One is a control byte that arrives while the commit unit is still busy. Another is a Start or Stop that lands in the middle of a byte. The bench models the commit unit's busy window itself and sends a polling control byte right after the Stop of a write, so the decision falls inside that window. It then repeats the poll after busy drops. The bench aborts a transfer by clocking a partial byte with a bit-level task before it issues the condition, and it checks the pointer afterwards with a current-address read. Page wrap and the wrap at the top of the array are reached with directed start addresses, and random writes and read-backs cover the remaining address space.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

    localparam logic [3:0] DEV_CODE  = 4'b1010;
    localparam int         CNT_W     = 4;
    localparam logic [CNT_W-1:0] BYTE_BITS = 4'd8;   // rise count at end of data bits
    localparam logic [CNT_W-1:0] ACK_DONE  = 4'd9;   // rise count after the ninth clock

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WDATA,
        ST_RDATA
    } eng_state_e;

    typedef struct packed {
        logic [3:0] code;
        logic [2:0] sel;
        logic       rd;
    } ctrl_byte_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic scl_low2;
    } bus_evt_t;

    function automatic logic ctrl_hit(ctrl_byte_t c, logic [2:0] strap);
        return (c.code == DEV_CODE) && (c.sel == strap);
    endfunction

endpackage

// File: rtl/i2cmem_cond.sv
module i2cmem_cond
    import i2cmem_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt.scl_rise = scl_i & ~scl_q;
        evt.scl_fall = ~scl_i & scl_q;
        evt.start    = scl_i & scl_q & sda_q & ~sda_i;
        evt.stop     = scl_i & scl_q & ~sda_q & sda_i;
        evt.scl_low2 = ~scl_i & ~scl_q;
    end

endmodule

// File: rtl/i2cmem_ptr.sv
module i2cmem_ptr #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_page,
    input  logic              inc_full,
    output logic [ADDR_W-1:0] ptr
);

    logic [ADDR_W-1:0] page_next;

    generate
        if (PAGE_W < ADDR_W) begin : g_paged
            assign page_next = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};

            AST_PAGE_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
                (inc_page && !load) |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])))
                else $error("upper pointer bits moved on page increment"); // R6
        end else begin : g_flat
            assign page_next = ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)           ptr <= '0;
        else if (load)     ptr <= load_val;
        else if (inc_page) ptr <= page_next;
        else if (inc_full) ptr <= ptr + 1'b1;
    end

    AST_TOP_WRAPS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (inc_full && !load && !inc_page && (ptr == {ADDR_W{1'b1}})) |=> (ptr == '0))
        else $error("read pointer did not wrap to zero"); // R10

endmodule

// File: rtl/i2cmem_sda_drv.sv
module i2cmem_sda_drv (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic scl_low2,
    input  logic want_oe,
    output logic oe_o
);

    always_ff @(posedge clk) begin
        if (rst)           oe_o <= 1'b0;
        else if (scl_low2) oe_o <= want_oe;
    end

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe_o) |-> (!$past(scl_i) && !$past(scl_i, 2)))
        else $error("SDA drive changed while SCL high"); // R12

endmodule

// File: rtl/i2cmem_slave.sv
module i2cmem_slave
    import i2cmem_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    input  logic              busy_i,
    input  logic [7:0]        mem_rdata_i,
    output logic              sda_oe_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic [7:0]        mem_wdata_o,
    output logic              commit_o
);

    localparam int HI_W = ADDR_W - 8;

    bus_evt_t         evt;
    eng_state_e       state;
    logic [CNT_W-1:0] bit_cnt;
    logic [7:0]       shreg;
    logic             ack_drv;
    logic             rd_mode;
    logic             mack;
    logic             wrote;
    logic [HI_W-1:0]  hi_q;
    logic             we_q;
    logic [7:0]       wdata_q;
    logic             commit_q;
    logic             want_oe;
    logic             ld;
    logic             inc_full;
    logic             byte_end;

    i2cmem_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    assign byte_end = evt.scl_fall && (bit_cnt == BYTE_BITS);
    assign ld       = byte_end && (state == ST_ADDR_LO);
    assign inc_full = byte_end && (state == ST_RDATA);

    i2cmem_ptr #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val ({hi_q, shreg}),
        .inc_page (we_q),
        .inc_full (inc_full),
        .ptr      (mem_addr_o)
    );

    assign want_oe = (state == ST_RDATA && bit_cnt < BYTE_BITS) ? ~shreg[7] : ack_drv;

    i2cmem_sda_drv u_drv (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_i),
        .scl_low2 (evt.scl_low2),
        .want_oe  (want_oe),
        .oe_o     (sda_oe_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            ack_drv  <= 1'b0;
            rd_mode  <= 1'b0;
            mack     <= 1'b0;
            wrote    <= 1'b0;
            hi_q     <= '0;
            we_q     <= 1'b0;
            wdata_q  <= '0;
            commit_q <= 1'b0;
        end else begin
            we_q     <= 1'b0;
            commit_q <= 1'b0;
            if (evt.start) begin
                state   <= ST_CTRL;
                bit_cnt <= '0;
                ack_drv <= 1'b0;
                wrote   <= 1'b0;
            end else if (evt.stop) begin
                commit_q <= (state == ST_WDATA) && wrote;
                state    <= ST_IDLE;
                bit_cnt  <= '0;
                ack_drv  <= 1'b0;
                wrote    <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (evt.scl_rise) begin
                    if (bit_cnt < BYTE_BITS) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (state != ST_RDATA) shreg <= {shreg[6:0], sda_i};
                    end else if (bit_cnt == BYTE_BITS) begin
                        bit_cnt <= ACK_DONE;
                        if (state == ST_RDATA) mack <= ~sda_i;
                    end
                end else if (evt.scl_fall) begin
                    if (bit_cnt == BYTE_BITS) begin
                        case (state)
                            ST_CTRL: begin
                                if (ctrl_hit(ctrl_byte_t'(shreg), strap_i) && !busy_i) begin
                                    ack_drv <= 1'b1;
                                    rd_mode <= shreg[0];
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            ST_ADDR_HI: begin
                                ack_drv <= 1'b1;
                                hi_q    <= shreg[HI_W-1:0];
                            end
                            ST_ADDR_LO: ack_drv <= 1'b1;
                            ST_WDATA: begin
                                ack_drv <= 1'b1;
                                we_q    <= 1'b1;
                                wdata_q <= shreg;
                                wrote   <= 1'b1;
                            end
                            default: ;
                        endcase
                    end else if (bit_cnt == ACK_DONE) begin
                        ack_drv <= 1'b0;
                        bit_cnt <= '0;
                        case (state)
                            ST_CTRL: begin
                                if (rd_mode) begin
                                    state <= ST_RDATA;
                                    shreg <= mem_rdata_i;
                                end else begin
                                    state <= ST_ADDR_HI;
                                end
                            end
                            ST_ADDR_HI: state <= ST_ADDR_LO;
                            ST_ADDR_LO: state <= ST_WDATA;
                            ST_RDATA: begin
                                if (mack) shreg <= mem_rdata_i;
                                else      state <= ST_IDLE;
                            end
                            default: ;
                        endcase
                    end else if (state == ST_RDATA && bit_cnt != '0) begin
                        shreg <= {shreg[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign mem_we_o    = we_q;
    assign mem_wdata_o = wdata_q;
    assign commit_o    = commit_q;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= ACK_DONE)
        else $error("bit counter out of range"); // R2

    AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        ($rose(ack_drv) && state == ST_CTRL) |-> !$past(busy_i))
        else $error("control byte acknowledged while busy"); // R4

    AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !ack_drv)
        else $error("acknowledge pending in idle"); // R3

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |=> !mem_we_o)
        else $error("write strobe longer than one cycle"); // R5

    AST_COMMIT_AT_IDLE: assert property (@(posedge clk) disable iff (rst)
        commit_o |-> (state == ST_IDLE))
        else $error("commit outside a Stop"); // R7

endmodule

// File: tb/i2cmem_slave_test.sv
module i2cmem_slave_test;

    localparam int Q        = 8;
    localparam int BUSY_CYC = 600;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  strap = 3'b101;
    int          busy_cnt = 0;
    logic        busy;
    logic [7:0]  rdata_q = 8'h00;
    logic        sda_oe;
    logic [14:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic        commit;
    wire         sda_line = sda_m & ~sda_oe;

    int tests = 0, fails = 0, commits = 0, oe_viol = 0;
    logic oe_seen = 1'b0, prev_oe = 1'b0, prev_scl = 1'b1, done = 1'b0;
    logic [14:0] exp_ptr = '0;
    logic [7:0] wbuf [8];
    logic [7:0] bmem [int];
    logic [7:0] emem [int];

    always #5 clk = ~clk;
    assign busy = (busy_cnt != 0);

    i2cmem_slave uut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .strap_i     (strap),
        .busy_i      (busy),
        .mem_rdata_i (rdata_q),
        .sda_oe_o    (sda_oe),
        .mem_addr_o  (mem_addr),
        .mem_we_o    (mem_we),
        .mem_wdata_o (mem_wdata),
        .commit_o    (commit)
    );

    function automatic logic [7:0] init_val(int a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction
    function automatic logic [7:0] rd_b(int a);
        if (bmem.exists(a)) return bmem[a];
        return init_val(a);
    endfunction
    function automatic logic [7:0] rd_e(int a);
        if (emem.exists(a)) return emem[a];
        return init_val(a);
    endfunction
    function automatic logic [7:0] ctrl(logic rd);
        return {4'b1010, strap, rd};
    endfunction
    function automatic logic [14:0] page_inc(logic [14:0] a);
        return {a[14:6], a[5:0] + 6'd1};
    endfunction

    // memory model and monitor, sampled 1 ns after the active edge
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (sda_oe !== prev_oe && (scl_m || prev_scl)) oe_viol++;
            if (sda_oe) oe_seen = 1'b1;
            if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
            if (commit) begin commits++; busy_cnt = BUSY_CYC; end
            else if (busy_cnt > 0) busy_cnt--;
        end
        prev_oe  = sda_oe;
        prev_scl = scl_m;
        rdata_q  = rd_b(int'(mem_addr));
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic do_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(Q / 2);
        seen = sda_line; tick(Q / 2);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
        clk_bit(!ack, s);
    endtask

    task automatic wait_idle;
        while (busy) tick(1);
        tick(4);
    endtask

    // write n bytes from wbuf starting at raw 16-bit address a
    task automatic wr_seq(input logic [15:0] a, input int n, output int acks);
        logic k;
        logic [14:0] p;
        acks = 0;
        do_start;
        send_byte(ctrl(1'b0), k); acks += int'(k);
        send_byte(a[15:8], k);    acks += int'(k);
        send_byte(a[7:0], k);     acks += int'(k);
        p = a[14:0];
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], k); acks += int'(k);
            emem[int'(p)] = wbuf[i];
            p = page_inc(p);
        end
        exp_ptr = p;
        do_stop;
    endtask

    task automatic rand_read(input logic [14:0] a, input int n, input string req);
        logic k;
        logic [7:0] b;
        logic [14:0] p;
        do_start;
        send_byte(ctrl(1'b0), k);
        send_byte({1'b0, a[14:8]}, k);
        send_byte(a[7:0], k);
        do_start;
        send_byte(ctrl(1'b1), k);
        chk("R2", "read control ack", k, 1);
        p = a;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            chk(req, "read data", b, rd_e(int'(p)));
            p = p + 15'd1;
        end
        exp_ptr = p;
        do_stop;
    endtask

    task automatic cur_read(input string req);
        logic k;
        logic [7:0] b;
        do_start;
        send_byte(ctrl(1'b1), k);
        recv_byte(1'b0, b);
        chk(req, "current read data", b, rd_e(int'(exp_ptr)));
        exp_ptr = exp_ptr + 15'd1;
        do_stop;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int acks, seed;
        logic k, s;
        logic [7:0] b;
        seed = $urandom(32'd24681);
        tick(5);
        rst = 1'b0;
        tick(3);
        chk("R1", "reset sda_oe", sda_oe, 0);
        chk("R1", "reset write strobe", mem_we, 0);
        chk("R7", "reset commit", commit, 0);

        // byte write, high address bit 7 set and ignored
        wbuf[0] = 8'hC3;
        wr_seq(16'h9234, 1, acks);
        chk("R5", "byte write acks", acks, 4);
        chk("R5", "byte at 0x1234", rd_b(32'h1234), 8'hC3);
        chk("R7", "commit after data", commits, 1);

        // polling during the busy window
        do_start;
        send_byte(ctrl(1'b0), k);
        chk("R4", "ack while busy", k, 0);
        do_stop;
        wait_idle;
        do_start;
        send_byte(ctrl(1'b0), k);
        chk("R4", "ack after busy", k, 1);
        do_stop;
        tick(4);
        chk("R7", "no commit without data", commits, 1);

        cur_read("R9");

        // control byte mismatches
        do_start;
        oe_seen = 1'b0;
        send_byte({4'b1010, strap ^ 3'b001, 1'b0}, k);
        chk("R3", "strap mismatch ack", k, 0);
        send_byte(8'h00, k);
        chk("R3", "no drive after mismatch", oe_seen, 0);
        do_stop;
        do_start;
        send_byte({4'b1011, strap, 1'b1}, k);
        chk("R3", "code mismatch ack", k, 0);
        do_stop;

        // page write wrapping inside a 64-byte page
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        wr_seq(16'h00FE, 4, acks);
        chk("R5", "page write acks", acks, 7);
        chk("R6", "byte at 0x0FE", rd_b(32'h0FE), 8'h11);
        chk("R6", "byte at 0x0FF", rd_b(32'h0FF), 8'h22);
        chk("R6", "byte at 0x0C0", rd_b(32'h0C0), 8'h33);
        chk("R6", "byte at 0x0C1", rd_b(32'h0C1), 8'h44);
        chk("R6", "byte at 0x100 untouched", rd_b(32'h100), init_val(32'h100));
        wait_idle;
        cur_read("R9");

        rand_read(15'h00FF, 3, "R8");
        cur_read("R9");
        rand_read(15'h7FFF, 2, "R10");

        // master NACK then more clocks: slave must stay off the line
        do_start;
        send_byte(ctrl(1'b1), k);
        recv_byte(1'b0, b);
        chk("R11", "data before nack", b, rd_e(int'(exp_ptr)));
        exp_ptr = exp_ptr + 15'd1;
        oe_seen = 1'b0;
        recv_byte(1'b0, b);
        chk("R11", "line after nack", b, 8'hFF);
        chk("R11", "no drive after nack", oe_seen, 0);
        do_stop;

        // Stop in the middle of an address byte
        do_start;
        send_byte(ctrl(1'b0), k);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
        do_stop;
        cur_read("R1");

        // Start in the middle of a control byte
        do_start;
        for (int i = 0; i < 3; i++) clk_bit(1'b1, s);
        do_start;
        send_byte(ctrl(1'b1), k);
        chk("R1", "ack after mid-byte start", k, 1);
        recv_byte(1'b0, b);
        chk("R1", "data after mid-byte start", b, rd_e(int'(exp_ptr)));
        exp_ptr = exp_ptr + 15'd1;
        do_stop;

        // random writes and read-backs
        for (int t = 0; t < 6; t++) begin
            logic [15:0] a;
            int n;
            a = 16'($urandom);
            n = 1 + int'($urandom % 5);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            wr_seq(a, n, acks);
            chk("R5", "random write acks", acks, n + 3);
            wait_idle;
            rand_read(a[14:0], n, "R8");
        end

        chk("R12", "sda drive changes with SCL high", oe_viol, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule